// File: doc/BRIEF.md
# SPI Slave Boot Byte Receiver with Selectable Hold-Off Flag

This block sits on the SPI pins of a chip that loads its boot image from an outside host. The host drives the clock and the chip acts only as the slave. The block synchronises SCK, MOSI and the chip select into the system clock. It builds bytes most significant bit first and hands them to an internal consumer over a valid/ready stream.

When the consumer falls behind, the host has to pause. The block drives one line out of a bank of flag outputs high for as long as it cannot take more bytes. The line's index comes from the stream itself: the first two bytes form a 16-bit header word, low byte first. Bits 8 down to 5 of that word select the flag line. Until the header has arrived, line 0 is used. Both header bytes are also passed downstream like any other byte.

A two-slot buffer sits between the shift register and the stream output. The hold-off flag rises as soon as one slot is occupied, so a byte the host had already started still finds room. A busy input from the consumer raises the flag as well. MISO is held at zero.

Top module: `spi_boot_rx`

## Requirements
- R1: Each byte is assembled from MOSI, sampled on the rising edge of SCK while cs_n is low, most significant bit first. Bytes are delivered on out_data in the order they were received.
- R2: Raising cs_n throws away a partly received byte. SCK edges seen while cs_n is high produce no byte.
- R3: The buffer holds up to two bytes. A byte that completes while one byte is waiting is kept and comes out second. While out_valid is high and out_ready is low, out_valid and out_data stay unchanged.
- R4: The selected flag output is high while the buffer holds at least one byte or busy is high. All flag outputs are low once the buffer is empty and busy is low. The flag follows its cause within two system clock cycles.
- R5: The header word is {second byte, first byte}, counted from reset. Bits 8 down to 5 of the header word form the flag index (header bytes E0h then 01h select flag 15). Both header bytes are forwarded on out_data.
- R6: Until the second header byte has been received, the flag index is 0.
- R7: At most one flag output is high at any time, and flag outputs that are not selected stay low.
- R8: miso is always 0.
- R9: Synchronous reset clears the flags, empties the buffer (out_valid low) and returns the flag index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI clock from the host |
| mosi | input | 1 | SPI data from the host |
| cs_n | input | 1 | SPI chip select, active low |
| miso | output | 1 | SPI data to the host, constant 0 |
| hold_flags | output | FLAG_N (16) | Hold-off flag bank, active high, at most one line set |
| out_data | output | 8 | Received byte at the head of the buffer |
| out_valid | output | 1 | out_data holds a byte |
| out_ready | input | 1 | Consumer takes the byte this cycle |
| busy | input | 1 | Consumer is busy; forces hold-off |

## Verification
The header is sent first with the consumer stalled. Its first byte shows flag 0 in use, and its second byte shows flag 15 taking over, which confirms that bits 8 down to 5 are decoded from a low-byte-first word. A table of bytes with alternating, all-ones, all-zero and single-bit patterns then tests bit order and per-byte flag behaviour. Two bytes are sent back to back without draining, which tests storage in the second slot and the delivery order. A byte cut short by cs_n, SCK toggling with cs_n high, the busy input on an empty buffer, and a second reset show that partial data is discarded, that busy alone raises the flag, and that the index returns to 0.

// File: rtl/spb_pkg.sv
package spb_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/spb_sync.sv
module spb_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spb_shift.sv
module spb_shift
  import spb_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sck_s,
  input  logic  mosi_s,
  input  logic  csn_s,
  output byte_t byte_o,
  output logic  byte_stb
);
  localparam int CW = $clog2(BYTE_W);

  logic              sck_d;
  logic [BYTE_W-2:0] sr;
  logic [CW-1:0]     bitcnt;
  logic              rise;

  assign rise = sck_s & ~sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d    <= 1'b0;
      sr       <= '0;
      bitcnt   <= '0;
      byte_o   <= '0;
      byte_stb <= 1'b0;
    end else begin
      sck_d    <= sck_s;
      byte_stb <= 1'b0;
      if (csn_s) begin
        bitcnt <= '0;
      end else if (rise) begin
        sr <= {sr[BYTE_W-3:0], mosi_s};
        if (bitcnt == CW'(BYTE_W - 1)) begin
          byte_o   <= {sr, mosi_s};
          byte_stb <= 1'b1;
          bitcnt   <= '0;
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spb_fifo.sv
module spb_fifo
  import spb_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    push,
  input  byte_t   wr_data,
  input  logic    pop,
  output byte_t   rd_data,
  output logic    not_empty,
  output logic [AW:0] level
);
  byte_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign do_push   = push && (level < (AW+1)'(DEPTH));
  assign do_pop    = pop && (level != '0);
  assign not_empty = (level != '0);
  assign rd_data   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      level <= level + 1'b1;
      else if (!do_push && do_pop) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/spb_hdr.sv
module spb_hdr
  import spb_pkg::*;
#(
  parameter int IDX_LSB = 5,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  byte_t            data,
  output logic [IDX_W-1:0] idx
);
  localparam int HDR_W = 2 * BYTE_W;

  byte_t             lo;
  logic [1:0]        seen;
  logic [HDR_W-1:0]  word;

  assign word = {data, lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo   <= '0;
      seen <= '0;
      idx  <= '0;
    end else if (stb && seen != 2'd2) begin
      seen <= seen + 1'b1;
      if (seen == 2'd0) lo <= data;
      else              idx <= word[IDX_LSB +: IDX_W];
    end
  end
endmodule

// File: rtl/spi_boot_rx.sv
module spi_boot_rx
  import spb_pkg::*;
#(
  parameter int FLAG_N  = 16,
  parameter int IDX_LSB = 5,
  parameter int IDX_W   = 4,
  parameter int DEPTH   = 2,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              mosi,
  input  logic              cs_n,
  output logic              miso,
  output logic [FLAG_N-1:0] hold_flags,
  output logic [7:0]        out_data,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic              busy
);
  logic [2:0]       pins_s;
  byte_t            rx_byte;
  logic             rx_stb;
  logic [IDX_W-1:0] flag_idx;
  logic [AW:0]      level;
  logic             hold_c;

  spb_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sck, mosi}),
    .q   (pins_s)
  );

  spb_shift u_shift (
    .clk      (clk),
    .rst      (rst),
    .sck_s    (pins_s[1]),
    .mosi_s   (pins_s[0]),
    .csn_s    (pins_s[2]),
    .byte_o   (rx_byte),
    .byte_stb (rx_stb)
  );

  spb_hdr #(.IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_hdr (
    .clk  (clk),
    .rst  (rst),
    .stb  (rx_stb),
    .data (rx_byte),
    .idx  (flag_idx)
  );

  spb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (rx_stb),
    .wr_data   (rx_byte),
    .pop       (out_ready),
    .rd_data   (out_data),
    .not_empty (out_valid),
    .level     (level)
  );

  assign hold_c = busy || (level != '0);
  assign miso   = 1'b0;

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) hold_flags[i] <= 1'b0;
      else     hold_flags[i] <= hold_c && (flag_idx == IDX_W'(i));
    end
  end
endmodule

// File: rtl/spi_boot_rx_chk.sv
module spi_boot_rx_chk #(
  parameter int FLAG_N = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              miso,
  input logic [FLAG_N-1:0] hold_flags,
  input logic [7:0]        out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              busy
);
  p_flags_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hold_flags));

  p_miso_low_r8: assert property (@(posedge clk) miso == 1'b0);

  p_busy_raises_r4: assert property (@(posedge clk) disable iff (rst)
    busy |=> (hold_flags != '0));

  p_idle_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && !out_valid) |=> (hold_flags == '0));

  p_valid_held_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);

  p_data_held_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (hold_flags == '0 && !out_valid));
endmodule

bind spi_boot_rx spi_boot_rx_chk #(.FLAG_N(FLAG_N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .miso       (miso),
  .hold_flags (hold_flags),
  .out_data   (out_data),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .busy       (busy)
);

// File: tb/tb_spi_boot_rx.sv
module tb_spi_boot_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b0;
  logic        mosi = 1'b0;
  logic        cs_n = 1'b1;
  logic        out_ready = 1'b0;
  logic        busy = 1'b0;
  logic        miso;
  logic [15:0] hold_flags;
  logic [7:0]  out_data;
  logic        out_valid;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  spi_boot_rx dut (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .miso(miso), .hold_flags(hold_flags), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .busy(busy)
  );

  // {byte sent, expected flags while it waits}
  localparam logic [23:0] VEC [6] = '{
    {8'hA5, 16'h8000}, {8'h5A, 16'h8000}, {8'hFF, 16'h8000},
    {8'h00, 16'h8000}, {8'h80, 16'h8000}, {8'h01, 16'h8000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = b[i];
      wait_n(8);
      sck = 1'b1;
      wait_n(8);
      sck = 1'b0;
    end
    wait_n(12);
  endtask

  task automatic pop;
    out_ready = 1'b1;
    wait_n(1);
    out_ready = 1'b0;
    wait_n(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(2);
    check("R9 flags", hold_flags, 16'h0);
    check("R9 valid", out_valid, 1'b0);
    check("R8 miso", miso, 1'b0);

    cs_n = 1'b0;
    wait_n(4);
    // header low byte: default index 0
    spi_bits(8'hE0, 8);
    check("R1 data", out_data, 8'hE0);
    check("R3 valid", out_valid, 1'b1);
    check("R6 default flag", hold_flags, 16'h0001);
    pop;
    check("R4 flags clear", hold_flags, 16'h0);
    // header high byte: index 15
    spi_bits(8'h01, 8);
    check("R5 forwarded", out_data, 8'h01);
    check("R5 flag 15", hold_flags, 16'h8000);
    pop;

    for (int k = 0; k < 6; k++) begin
      spi_bits(VEC[k][23:16], 8);
      check("R1 table data", out_data, VEC[k][23:16]);
      check("R7 table flags", hold_flags, VEC[k][15:0]);
      pop;
      check("R4 table clear", hold_flags, 16'h0);
    end

    // two bytes without draining
    spi_bits(8'h3C, 8);
    spi_bits(8'hC3, 8);
    check("R3 first", out_data, 8'h3C);
    pop;
    check("R3 second", out_data, 8'hC3);
    check("R3 still valid", out_valid, 1'b1);
    pop;
    check("R3 empty", out_valid, 1'b0);

    // partial byte cut by cs_n, then idle clocks
    spi_bits(8'hFF, 3);
    cs_n = 1'b1;
    wait_n(6);
    spi_bits(8'hFF, 8);
    check("R2 no byte", out_valid, 1'b0);
    check("R2 no flag", hold_flags, 16'h0);
    cs_n = 1'b0;
    wait_n(6);
    spi_bits(8'h5A, 8);
    check("R2 clean byte", out_data, 8'h5A);
    pop;
    check("R2 single byte", out_valid, 1'b0);

    // busy alone
    busy = 1'b1;
    wait_n(3);
    check("R4 busy flag", hold_flags, 16'h8000);
    check("R7 one flag", $countones(hold_flags), 1);
    busy = 1'b0;
    wait_n(3);
    check("R4 busy release", hold_flags, 16'h0);

    // reset returns index to 0
    rst = 1'b1;
    wait_n(3);
    rst = 1'b0;
    wait_n(2);
    check("R9 reset valid", out_valid, 1'b0);
    spi_bits(8'h77, 8);
    check("R9 index zero", hold_flags, 16'h0001);
    pop;
    check("R8 miso end", miso, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule